// File: doc/BRIEF.md
# Event-Vectored Interrupt Queue Controller

This block turns numbered motion and placement events into start requests for a small processor core that runs one short handler per request. Software first fills a vector table that binds event numbers to handler entry addresses, then turns interrupts on. Each event whose number is bound is then placed into an in-order queue. A software trap can also place any entry address into the same queue. The queue is served one entry at a time. The core gets a start pulse with the entry address, runs the handler, and reports halt on `core_done`. Only then is the next entry started, so a handler is never cut short by another.

Two state machines do the work. The mode machine has three states: `M_OFF` (interrupts disabled), `M_ON` (enabled) and `M_DRAIN` (disable requested, queue still being served). Its transitions are: enable, `M_OFF`→`M_ON` on `ena_req`; disable, `M_ON`→`M_DRAIN` on `dis_req`; drained, `M_DRAIN`→`M_OFF` once the queue is empty and no handler runs. The dispatch machine has two states: `D_IDLE` and `D_RUN`. Its transitions are: launch, `D_IDLE`→`D_RUN` when the queue holds an entry; halt, `D_RUN`→`D_IDLE` on `core_done`.

The vector table may only be rewritten in `M_OFF`. Disabling first stops new queue entries. It then waits until every queued handler has run before it reports completion with a one-cycle `disable_done`.

Top module: `irqv_top`

## Requirements
- R1: After reset the block is in `M_OFF` with `enabled`=0, `draining`=0, `q_level`=0, `overflow`=0, `cfg_err`=0, `trap_err`=0, `handler_busy`=0 and `core_start`=0, and every event number is unbound.
- R2: Event numbers are 3-bit codes: 0 forward move, 1 upward move, 2 downward move, 3 left turn, 4 right turn, 5 forward place, 6 upward place, 7 downward place. In `M_ON`, an `evt_valid` cycle with a bound `evt_id` queues that binding's address. The core later gets `core_start` high for exactly one cycle, with `core_addr` equal to that address. `core_start` can appear at the earliest in the cycle after the event is sampled.
- R3: An event with an unbound number, or any event outside `M_ON`, is not queued. `q_level` does not change and no start results.
- R4: A binding write (`cfg_we`) or a clear (`cfg_clr`) outside `M_OFF` is refused. `cfg_err` goes high in the following cycle for one cycle, and the table keeps its old contents.
- R5: A clear accepted in `M_OFF` removes every binding. If both a clear and a binding write arrive in the same cycle, the clear wins.
- R6: In `M_ON`, `trap_req` queues `trap_addr`. Outside `M_ON`, the trap is refused: nothing is queued and `trap_err` goes high in the following cycle.
- R7: While a handler runs (`handler_busy`=1), no `core_start` is issued. The running handler ends only on `core_done`. Entries start in the order they were queued.
- R8: When an accepted event and a trap arrive in the same cycle, the event's address is queued ahead of the trap address.
- R9: The queue holds DEPTH entries (8 by default). The full test uses the occupancy before any same-cycle removal. A request that finds no room is dropped and sets `overflow`, which stays set until reset.
- R10: `dis_req` in `M_ON` enters `M_DRAIN`. There, events are ignored and traps are refused. Once the queue is empty and the core is idle, `disable_done` pulses for one cycle and the block returns to `M_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is present this cycle |
| evt_id | input | ID_W | Event number (3 bits by default) |
| cfg_we | input | 1 | Write one vector table binding |
| cfg_clr | input | 1 | Remove all bindings |
| cfg_id | input | ID_W | Event number for the binding write |
| cfg_addr | input | ADDR_W | Entry address for the binding write |
| trap_req | input | 1 | Software trap request |
| trap_addr | input | ADDR_W | Entry address carried by the trap |
| ena_req | input | 1 | Enable interrupts |
| dis_req | input | 1 | Disable interrupts and drain the queue |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_addr | output | ADDR_W | Entry address that goes with the start pulse |
| core_done | input | 1 | Core reports that the handler has halted |
| cfg_err | output | 1 | Refused table write or clear (one cycle) |
| trap_err | output | 1 | Refused trap (one cycle) |
| overflow | output | 1 | Sticky: a queue request was dropped |
| enabled | output | 1 | Mode is `M_ON` |
| draining | output | 1 | Mode is `M_DRAIN` |
| handler_busy | output | 1 | Dispatch state is `D_RUN` |
| disable_done | output | 1 | One-cycle pulse when the drain completes |
| q_level | output | LVL_W | Number of queued entries |

## Verification
The bench builds the block with its defaults: eight event numbers, 11-bit entry addresses and an 8-entry queue. The queue is shallow enough that a burst of back-to-back events reaches the full boundary, and overflow is observable, within a dozen cycles. A core model whose handler length the bench sets lets a long handler hold entries in the queue. That exposes the same-cycle event-and-trap ordering, and a disable that must wait for nine queued handlers to run.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    // Mode machine: interrupts off, on, or draining after a disable request
    typedef enum logic [1:0] {
        M_OFF   = 2'd0,
        M_ON    = 2'd1,
        M_DRAIN = 2'd2
    } mode_t;

    // Dispatch machine: waiting for work, or a handler is running on the core
    typedef enum logic {
        D_IDLE = 1'b0,
        D_RUN  = 1'b1
    } disp_t;

    // Built-in event numbers
    localparam int unsigned EV_MOVE_FWD   = 0;
    localparam int unsigned EV_MOVE_UP    = 1;
    localparam int unsigned EV_MOVE_DOWN  = 2;
    localparam int unsigned EV_TURN_LEFT  = 3;
    localparam int unsigned EV_TURN_RIGHT = 4;
    localparam int unsigned EV_PLACE_FWD  = 5;
    localparam int unsigned EV_PLACE_UP   = 6;
    localparam int unsigned EV_PLACE_DOWN = 7;

endpackage

// File: rtl/irqv_vtable.sv
module irqv_vtable #(
    parameter int unsigned NUM_EVT = 8,
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned ID_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [ID_W-1:0]   wid,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ID_W-1:0]   lid,
    output logic              hit,
    output logic [ADDR_W-1:0] addr
);

    logic [NUM_EVT-1:0] bound_q;
    logic [ADDR_W-1:0]  vec_q [NUM_EVT];

    // One entry per event number; clear has priority over a write
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_entry
        logic sel;
        assign sel = we && (wid == ID_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bound_q[g] <= 1'b0;
            end else if (clr) begin
                bound_q[g] <= 1'b0;
            end else if (sel) begin
                bound_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !clr) begin
                vec_q[g] <= waddr;
            end
        end
    end

    always_comb begin
        hit  = 1'b0;
        addr = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (lid == ID_W'(i)) begin
                hit  = bound_q[i];
                addr = vec_q[i];
            end
        end
    end

endmodule

// File: rtl/irqv_fifo.sv
module irqv_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 11,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_a,
    input  logic [W-1:0]     din_a,
    input  logic             req_b,
    input  logic [W-1:0]     din_b,
    input  logic             pop,
    output logic             acc_a,
    output logic             acc_b,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] level,
    output logic             empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q, wr_b;
    logic [CNT_W-1:0] cnt_q, space;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    // Room is judged on the occupancy before a same-cycle pop; port a wins
    assign space = CNT_W'(DEPTH) - cnt_q;
    assign acc_a = req_a && (space != '0);
    assign acc_b = req_b && (space > CNT_W'(acc_a));
    assign wr_b  = acc_a ? ptr_inc(wr_q) : wr_q;

    always_ff @(posedge clk) begin
        if (acc_a) begin
            mem[wr_q] <= din_a;
        end
        if (acc_b) begin
            mem[wr_b] <= din_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (acc_b) begin
                wr_q <= ptr_inc(wr_b);
            end else if (acc_a) begin
                wr_q <= ptr_inc(wr_q);
            end
            if (pop) begin
                rd_q <= ptr_inc(rd_q);
            end
            cnt_q <= cnt_q + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop);
        end
    end

    assign head  = mem[rd_q];
    assign level = cnt_q;
    assign empty = (cnt_q == '0);

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ena_req,
    input  logic dis_req,
    input  logic cfg_we,
    input  logic cfg_clr,
    input  logic trap_req,
    input  logic evt_valid,
    input  logic evt_hit,
    input  logic q_empty,
    input  logic core_done,
    input  logic drop,
    output logic tbl_we,
    output logic tbl_clr,
    output logic push_evt,
    output logic push_trap,
    output logic pop,
    output logic core_start,
    output logic enabled,
    output logic draining,
    output logic handler_busy,
    output logic disable_done,
    output logic cfg_err,
    output logic trap_err,
    output logic overflow
);

    mode_t mode_q, mode_d;
    disp_t disp_q, disp_d;
    logic  drained;
    logic  cfg_err_q, trap_err_q, ovf_q;

    assign drained = (mode_q == M_DRAIN) && q_empty && (disp_q == D_IDLE);

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_OFF;
            disp_q <= D_IDLE;
        end else begin
            mode_q <= mode_d;
            disp_q <= disp_d;
        end
    end

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_OFF:   if (ena_req) mode_d = M_ON;
            M_ON:    if (dis_req) mode_d = M_DRAIN;
            M_DRAIN: if (drained) mode_d = M_OFF;
            default: mode_d = M_OFF;
        endcase

        disp_d = disp_q;
        unique case (disp_q)
            D_IDLE: if (!q_empty) disp_d = D_RUN;
            D_RUN:  if (core_done) disp_d = D_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        enabled      = (mode_q == M_ON);
        draining     = (mode_q == M_DRAIN);
        handler_busy = (disp_q == D_RUN);
        core_start   = (disp_q == D_IDLE) && !q_empty;
        pop          = core_start;
        disable_done = drained;
        push_evt     = enabled && evt_valid && evt_hit;
        push_trap    = enabled && trap_req;
        tbl_we       = (mode_q == M_OFF) && cfg_we;
        tbl_clr      = (mode_q == M_OFF) && cfg_clr;
    end

    // Registered error pulses and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err_q  <= 1'b0;
            trap_err_q <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            cfg_err_q  <= (cfg_we || cfg_clr) && (mode_q != M_OFF);
            trap_err_q <= trap_req && (mode_q != M_ON);
            ovf_q      <= ovf_q || drop;
        end
    end

    assign cfg_err  = cfg_err_q;
    assign trap_err = trap_err_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
    parameter int unsigned NUM_EVT = 8,
    parameter int unsigned ADDR_W  = 11,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned ID_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
    parameter int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              cfg_we,
    input  logic              cfg_clr,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              trap_req,
    input  logic [ADDR_W-1:0] trap_addr,
    input  logic              ena_req,
    input  logic              dis_req,
    output logic              core_start,
    output logic [ADDR_W-1:0] core_addr,
    input  logic              core_done,
    output logic              cfg_err,
    output logic              trap_err,
    output logic              overflow,
    output logic              enabled,
    output logic              draining,
    output logic              handler_busy,
    output logic              disable_done,
    output logic [LVL_W-1:0]  q_level
);

    logic              tbl_we, tbl_clr, evt_hit;
    logic [ADDR_W-1:0] evt_addr;
    logic              push_evt, push_trap, acc_evt, acc_trap;
    logic              pop, q_empty, drop;

    irqv_vtable #(
        .NUM_EVT (NUM_EVT),
        .ADDR_W  (ADDR_W),
        .ID_W    (ID_W)
    ) u_vtable (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tbl_clr),
        .we    (tbl_we),
        .wid   (cfg_id),
        .waddr (cfg_addr),
        .lid   (evt_id),
        .hit   (evt_hit),
        .addr  (evt_addr)
    );

    // Port a carries the event so it is queued ahead of a same-cycle trap
    irqv_fifo #(
        .DEPTH (DEPTH),
        .W     (ADDR_W),
        .CNT_W (LVL_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .req_a (push_evt),
        .din_a (evt_addr),
        .req_b (push_trap),
        .din_b (trap_addr),
        .pop   (pop),
        .acc_a (acc_evt),
        .acc_b (acc_trap),
        .head  (core_addr),
        .level (q_level),
        .empty (q_empty)
    );

    assign drop = (push_evt && !acc_evt) || (push_trap && !acc_trap);

    irqv_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ena_req      (ena_req),
        .dis_req      (dis_req),
        .cfg_we       (cfg_we),
        .cfg_clr      (cfg_clr),
        .trap_req     (trap_req),
        .evt_valid    (evt_valid),
        .evt_hit      (evt_hit),
        .q_empty      (q_empty),
        .core_done    (core_done),
        .drop         (drop),
        .tbl_we       (tbl_we),
        .tbl_clr      (tbl_clr),
        .push_evt     (push_evt),
        .push_trap    (push_trap),
        .pop          (pop),
        .core_start   (core_start),
        .enabled      (enabled),
        .draining     (draining),
        .handler_busy (handler_busy),
        .disable_done (disable_done),
        .cfg_err      (cfg_err),
        .trap_err     (trap_err),
        .overflow     (overflow)
    );

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_clr,
    input logic             trap_req,
    input logic             core_start,
    input logic             core_done,
    input logic             cfg_err,
    input logic             trap_err,
    input logic             overflow,
    input logic             enabled,
    input logic             draining,
    input logic             handler_busy,
    input logic             disable_done,
    input logic [LVL_W-1:0] q_level
);

    p_start_has_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (q_level != '0));

    p_off_queue_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !draining) |-> (q_level == '0));

    p_cfg_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($past(cfg_we || cfg_clr) && $past(enabled || draining)));

    p_trap_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_err |-> ($past(trap_req) && !$past(enabled)));

    p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    p_busy_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_busy |-> !core_start);

    p_busy_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_busy && !core_done) |=> handler_busy);

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LVL_W'(DEPTH));

    p_drain_no_growth_r10: assert property (@(posedge clk) disable iff (!rst_n)
        draining |=> (q_level <= $past(q_level)));

    p_done_then_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disable_done |=> (!enabled && !draining && !disable_done));

endmodule

bind irqv_top irqv_checker #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_clr      (cfg_clr),
    .trap_req     (trap_req),
    .core_start   (core_start),
    .core_done    (core_done),
    .cfg_err      (cfg_err),
    .trap_err     (trap_err),
    .overflow     (overflow),
    .enabled      (enabled),
    .draining     (draining),
    .handler_busy (handler_busy),
    .disable_done (disable_done),
    .q_level      (q_level)
);

// File: tb/tb_irqv_top.sv
`timescale 1ns/1ps
module tb_irqv_top;

    localparam int NE = 8;
    localparam int AW = 11;
    localparam int DP = 8;
    localparam int IW = 3;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_valid = 1'b0;
    logic [IW-1:0] evt_id = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_clr = 1'b0;
    logic [IW-1:0] cfg_id = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic          trap_req = 1'b0;
    logic [AW-1:0] trap_addr = '0;
    logic          ena_req = 1'b0;
    logic          dis_req = 1'b0;
    logic          core_done = 1'b0;
    logic          core_start;
    logic [AW-1:0] core_addr;
    logic          cfg_err, trap_err, overflow, enabled, draining;
    logic          handler_busy, disable_done;
    logic [LW-1:0] q_level;

    int checks = 0;
    int errors = 0;
    int hold   = 3;
    logic [AW-1:0] exp_q [$];

    always #10 clk = ~clk;

    irqv_top #(.NUM_EVT(NE), .ADDR_W(AW), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_id(evt_id),
        .cfg_we(cfg_we), .cfg_clr(cfg_clr), .cfg_id(cfg_id), .cfg_addr(cfg_addr),
        .trap_req(trap_req), .trap_addr(trap_addr), .ena_req(ena_req),
        .dis_req(dis_req), .core_start(core_start), .core_addr(core_addr),
        .core_done(core_done), .cfg_err(cfg_err), .trap_err(trap_err),
        .overflow(overflow), .enabled(enabled), .draining(draining),
        .handler_busy(handler_busy), .disable_done(disable_done), .q_level(q_level)
    );

    function automatic logic [AW-1:0] vec(int id);
        return AW'(256 + id * 16 + 3);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Core model and scoreboard monitor: checks each start against the queue
    initial begin
        forever begin
            if (core_start === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected start", 1, 0);
                end else begin
                    chk("R2 start address in order", int'(core_addr), int'(exp_q.pop_front()));
                end
                for (int i = 0; i < hold; i++) begin
                    @(negedge clk);
                    chk("R7 no start while handler runs", int'(core_start), 0);
                end
                core_done = 1'b1;
                @(negedge clk);
                core_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic send_evt(int id);
        evt_valid = 1'b1;
        evt_id    = IW'(id);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic send_expect(int id);
        exp_q.push_back(vec(id));
        send_evt(id);
    endtask

    task automatic do_cfg(bit clr, int id, int addr, output logic err);
        cfg_we   = !clr;
        cfg_clr  = clr;
        cfg_id   = IW'(id);
        cfg_addr = AW'(addr);
        @(negedge clk);
        err     = cfg_err;
        cfg_we  = 1'b0;
        cfg_clr = 1'b0;
    endtask

    task automatic do_trap(int addr, output logic err);
        trap_req  = 1'b1;
        trap_addr = AW'(addr);
        @(negedge clk);
        err      = trap_err;
        trap_req = 1'b0;
    endtask

    task automatic do_enable();
        ena_req = 1'b1;
        @(negedge clk);
        ena_req = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (disable_done !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " disable_done seen"}, int'(disable_done), 1);
        chk({tag, " all entries ran before done"}, exp_q.size(), 0);
        @(negedge clk);
        chk({tag, " done is one cycle"}, int'(disable_done), 0);
        chk({tag, " back to disabled"}, int'(enabled || draining), 0);
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((exp_q.size() != 0 || handler_busy || q_level != 0) && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        logic err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 enabled", int'(enabled), 0);
        chk("R1 draining", int'(draining), 0);
        chk("R1 q_level", int'(q_level), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 errors", int'(cfg_err || trap_err), 0);
        chk("R1 busy/start", int'(handler_busy || core_start), 0);

        // R1 table empty after reset: bound-looking event is not queued
        do_enable();
        chk("R1 enable", int'(enabled), 1);
        send_evt(3);
        chk("R1 no binding after reset", int'(q_level), 0);

        // R4 config refused while enabled
        do_cfg(1'b0, 3, 'h222, err);
        chk("R4 bind refused error", int'(err), 1);
        @(negedge clk);
        chk("R4 error is one cycle", int'(cfg_err), 0);
        do_cfg(1'b1, 0, 0, err);
        chk("R4 clear refused error", int'(err), 1);
        send_evt(3);
        chk("R4 refused bind had no effect", int'(q_level), 0);

        // R10 disable with empty queue
        dis_req = 1'b1;
        @(negedge clk);
        dis_req = 1'b0;
        wait_done("R10 empty");

        // Bind ids 0..6 while disabled; 7 stays unbound
        for (int i = 0; i < 7; i++) begin
            do_cfg(1'b0, i, int'(vec(i)), err);
            chk("R4 bind accepted when off", int'(err), 0);
        end

        // R3 events ignored when off; R6 trap refused when off
        send_evt(1);
        chk("R3 event ignored when off", int'(q_level), 0);
        do_trap('h300, err);
        chk("R6 trap refused when off", int'(err), 1);
        chk("R6 refused trap not queued", int'(q_level), 0);

        // R2 main dispatch
        do_enable();
        send_expect(0);
        repeat (2) @(negedge clk);
        send_expect(1);
        send_expect(4);
        wait_idle();
        send_evt(7);
        chk("R3 unbound event ignored", int'(q_level), 0);

        // R6 trap when enabled
        begin
            trap_req  = 1'b1;
            trap_addr = AW'('h7AB);
            exp_q.push_back(AW'('h7AB));
            @(negedge clk);
            trap_req = 1'b0;
            chk("R6 trap no error when on", int'(trap_err), 0);
        end
        wait_idle();

        // R8 event and trap in the same cycle while a handler runs
        hold = 20;
        send_expect(6);
        evt_valid = 1'b1;
        evt_id    = IW'(2);
        trap_req  = 1'b1;
        trap_addr = AW'('h055);
        exp_q.push_back(vec(2));
        exp_q.push_back(AW'('h055));
        @(negedge clk);
        evt_valid = 1'b0;
        trap_req  = 1'b0;
        chk("R8 both queued", int'(q_level), 2);
        wait_idle();

        // R9 overflow: 11 back-to-back events, one popped early, 2 dropped
        hold = 40;
        for (int i = 0; i < 11; i++) begin
            if (i < 9) exp_q.push_back(vec(i % 7));
            evt_valid = 1'b1;
            evt_id    = IW'(i % 7);
            @(negedge clk);
        end
        evt_valid = 1'b0;
        chk("R9 queue full", int'(q_level), DP);
        chk("R9 overflow set", int'(overflow), 1);

        // R10 drain with a full queue
        dis_req = 1'b1;
        @(negedge clk);
        dis_req = 1'b0;
        chk("R10 draining", int'(draining), 1);
        send_evt(0);
        chk("R10 no entry during drain", int'(q_level), DP);
        do_trap('h111, err);
        chk("R10 trap refused during drain", int'(err), 1);
        chk("R10 refused trap not queued", int'(q_level), DP);
        wait_done("R10 full");
        chk("R9 overflow sticky", int'(overflow), 1);

        // R5 clear removes all bindings
        hold = 3;
        do_cfg(1'b1, 0, 0, err);
        chk("R5 clear accepted", int'(err), 0);
        do_enable();
        for (int i = 0; i < 7; i++) begin
            send_evt(i);
        end
        repeat (2) @(negedge clk);
        chk("R5 no binding after clear", int'(q_level), 0);
        chk("R5 no handler after clear", int'(handler_busy), 0);
        chk("R2 scoreboard empty", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule